// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block sits on the host side of a flash part that has a command register and drives the whole closed-loop chip-erase procedure on its own. A one-cycle `start` pulse makes it raise the high-voltage enable, wait for the supply to settle, and then ask an external program sequencer to bring every byte to 00h. Once that sequencer acknowledges, the block applies erase pulses. Each pulse is the erase opcode written twice, followed by a timed wait. After each pulse the block walks the array byte by byte. For every byte it writes the verify opcode with the address, waits a recovery interval, then reads the byte and compares it with FFh.

If a byte reads back as anything other than FFh, the block applies another pulse and verifies again from that same byte. Bytes already found erased are not checked again. The pulse count covers the whole erase. When every byte verifies, the block writes the read-mode opcode, drops the high voltage and reports success with the number of pulses used. If the pulse limit is used up, it drops the high voltage and reports an error with the address that would not verify.

All flash traffic goes through a bus master port with two valid/ready channels. The command channel carries writes and read requests; the response channel returns read data. Back-pressure rules:
- On the command channel, the block holds `cmd_valid` and every payload field steady until `cmd_ready` is seen high at a clock edge.
- The block keeps at most one transaction outstanding.
- The block raises `rsp_ready` only while a read is outstanding and takes the first word offered while it is high.

All waits are counted in clock cycles.

Top module: `bulk_erase_seq`

## Requirements
- R1: A `start` pulse seen while idle sets `hv_en` at once. `prog_req` rises no sooner than SETTLE_CYC cycles later and stays high until `prog_ack` is seen. No flash command is issued before that acknowledge.
- R2: Each erase pulse is two command writes of data 20h. The first verify command is accepted no sooner than PULSE_CYC cycles after the second 20h write is accepted.
- R3: Verifying a byte is a write of data A0h with the byte address, then, no sooner than RECOV_CYC cycles later, a read of that same address. The byte counts as erased only when the read returns FFh.
- R4: After an erased byte the next verify uses the following address. After a non-FFh byte a new erase pulse follows and verification restarts at that same address. Addresses start at 0 and run up to 2^ADDR_W-1.
- R5: When the last address verifies, the block writes FFh, clears `hv_en`, and then pulses `done` for one cycle. `pulse_count` then holds the number of erase pulses applied, which is always at least one.
- R6: If a byte still fails after MAX_PULSES pulses (default 1000), the block clears `hv_en` without writing FFh. It then pulses `err` for one cycle, with `fail_addr` holding that byte's address and `pulse_count` equal to MAX_PULSES.
- R7: While `cmd_valid` is high and `cmd_ready` low, `cmd_valid`, `cmd_write` (1 = write, 0 = read), `cmd_addr` and `cmd_data` stay unchanged into the next cycle.
- R8: After reset, `hv_en`, `prog_req`, `cmd_valid`, `rsp_ready`, `done` and `err` are all low. A `start` pulse during a run has no effect on that run. `done` and `err` are never high together.
- R9: `hv_en` is high during every cycle in which `cmd_valid` or `prog_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a chip erase |
| hv_en | output | 1 | High-voltage supply enable |
| prog_req | output | 1 | Request to the external sequencer to program all bytes to 00h |
| prog_ack | input | 1 | One-cycle acknowledge that the program-to-zero step finished |
| cmd_valid | output | 1 | Command channel valid |
| cmd_ready | input | 1 | Command channel ready |
| cmd_write | output | 1 | 1 = write cmd_data to cmd_addr, 0 = read cmd_addr |
| cmd_addr | output | ADDR_W | Flash byte address |
| cmd_data | output | 8 | Command or data byte for writes |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Read data accepted |
| rsp_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle success indication |
| err | output | 1 | One-cycle pulse-limit failure indication |
| fail_addr | output | ADDR_W | Address that failed to verify, valid with err |
| pulse_count | output | clog2(MAX_PULSES+1) | Erase pulses applied in the last run |

## Verification
The hardest case to reach from the ports is the pulse-limit path. A byte has to keep failing verification for a thousand pulses while every byte before it has already passed. The bench's flash model therefore gives each byte a count of pulses it needs before it reads FFh. Setting one middle byte above the limit and a later byte higher still drives the error path and pins down which address must be reported. A byte that needs exactly the limit checks the boundary on the success side. Comparing the number of verify reads with the count expected when verification resumes at the failing byte exposes any restart from address 0.

// File: rtl/erase_pkg.sv
package erase_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] OP_ERASE     = 8'h20;
  localparam logic [DATA_W-1:0] OP_VERIFY    = 8'hA0;
  localparam logic [DATA_W-1:0] OP_READ_MODE = 8'hFF;
  localparam logic [DATA_W-1:0] BYTE_ERASED  = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HV_UP,
    ST_PREPROG,
    ST_SETUP,
    ST_ERASE,
    ST_PULSE,
    ST_VCMD,
    ST_RECOV,
    ST_READ,
    ST_RESET,
    ST_HV_DOWN
  } seq_state_e;

  typedef enum logic [1:0] {
    BP_IDLE,
    BP_REQ,
    BP_WAIT
  } bus_phase_e;

endpackage

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expire
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt_q <= value;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q <= W'(1)) begin
          run_q  <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/erase_bus_port.sv
module erase_bus_port
  import erase_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [AW-1:0]     go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              fin,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [AW-1:0]     cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);

  bus_phase_e ph_q;

  assign cmd_valid = (ph_q == BP_REQ);
  assign rsp_ready = (ph_q == BP_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= BP_IDLE;
      fin       <= 1'b0;
      rd_data   <= '0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      fin <= 1'b0;
      unique case (ph_q)
        BP_IDLE: begin
          if (go) begin
            cmd_write <= go_write;
            cmd_addr  <= go_addr;
            cmd_data  <= go_data;
            ph_q      <= BP_REQ;
          end
        end
        BP_REQ: begin
          if (cmd_ready) begin
            if (cmd_write) begin
              fin  <= 1'b1;
              ph_q <= BP_IDLE;
            end else begin
              ph_q <= BP_WAIT;
            end
          end
        end
        BP_WAIT: begin
          if (rsp_valid) begin
            rd_data <= rsp_data;
            fin     <= 1'b1;
            ph_q    <= BP_IDLE;
          end
        end
        default: ph_q <= BP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq
  import erase_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PULSE_CYC  = 500000,
  parameter int RECOV_CYC  = 300,
  parameter int SETTLE_CYC = 100,
  parameter int MAX_PULSES = 1000,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              hv_en,
  output logic              prog_req,
  input  logic              prog_ack,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [CNT_W-1:0]  pulse_count
);

  localparam int T_MAX0 = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int T_MAX  = (T_MAX0 > SETTLE_CYC) ? T_MAX0 : SETTLE_CYC;
  localparam int TMR_W  = $clog2(T_MAX + 1);

  localparam logic [TMR_W-1:0]  T_PULSE  = TMR_W'(PULSE_CYC);
  localparam logic [TMR_W-1:0]  T_RECOV  = TMR_W'(RECOV_CYC);
  localparam logic [TMR_W-1:0]  T_SETTLE = TMR_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0]  LIMIT    = CNT_W'(MAX_PULSES);
  localparam logic [ADDR_W-1:0] LAST     = {ADDR_W{1'b1}};

  seq_state_e         state_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   pcnt_q;
  logic               ok_q;

  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_exp;

  logic               bus_go;
  logic               bus_wr;
  logic [ADDR_W-1:0]  bus_addr;
  logic [DATA_W-1:0]  bus_data;
  logic               bus_fin;
  logic [DATA_W-1:0]  bus_rd;

  assign pulse_count = pcnt_q;

  erase_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .value  (tmr_val),
    .expire (tmr_exp)
  );

  erase_bus_port #(.AW(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (bus_go),
    .go_write  (bus_wr),
    .go_addr   (bus_addr),
    .go_data   (bus_data),
    .fin       (bus_fin),
    .rd_data   (bus_rd),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pcnt_q    <= '0;
      ok_q      <= 1'b0;
      hv_en     <= 1'b0;
      prog_req  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      fail_addr <= '0;
      tmr_load  <= 1'b0;
      tmr_val   <= '0;
      bus_go    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
    end else begin
      bus_go   <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            hv_en     <= 1'b1;
            fail_addr <= '0;
            tmr_val   <= T_SETTLE;
            tmr_load  <= 1'b1;
            state_q   <= ST_HV_UP;
          end
        end
        ST_HV_UP: begin
          if (tmr_exp) begin
            prog_req <= 1'b1;
            state_q  <= ST_PREPROG;
          end
        end
        ST_PREPROG: begin
          if (prog_ack) begin
            prog_req <= 1'b0;
            pcnt_q   <= '0;
            addr_q   <= '0;
            bus_go   <= 1'b1;
            bus_wr   <= 1'b1;
            bus_addr <= '0;
            bus_data <= OP_ERASE;
            state_q  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (bus_fin) begin
            bus_go   <= 1'b1;
            bus_wr   <= 1'b1;
            bus_addr <= '0;
            bus_data <= OP_ERASE;
            pcnt_q   <= pcnt_q + CNT_W'(1);
            state_q  <= ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (bus_fin) begin
            tmr_val  <= T_PULSE;
            tmr_load <= 1'b1;
            state_q  <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (tmr_exp) begin
            bus_go   <= 1'b1;
            bus_wr   <= 1'b1;
            bus_addr <= addr_q;
            bus_data <= OP_VERIFY;
            state_q  <= ST_VCMD;
          end
        end
        ST_VCMD: begin
          if (bus_fin) begin
            tmr_val  <= T_RECOV;
            tmr_load <= 1'b1;
            state_q  <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          if (tmr_exp) begin
            bus_go   <= 1'b1;
            bus_wr   <= 1'b0;
            bus_addr <= addr_q;
            bus_data <= '0;
            state_q  <= ST_READ;
          end
        end
        ST_READ: begin
          if (bus_fin) begin
            if (bus_rd == BYTE_ERASED) begin
              if (addr_q == LAST) begin
                bus_go   <= 1'b1;
                bus_wr   <= 1'b1;
                bus_addr <= '0;
                bus_data <= OP_READ_MODE;
                state_q  <= ST_RESET;
              end else begin
                addr_q   <= addr_q + ADDR_W'(1);
                bus_go   <= 1'b1;
                bus_wr   <= 1'b1;
                bus_addr <= addr_q + ADDR_W'(1);
                bus_data <= OP_VERIFY;
                state_q  <= ST_VCMD;
              end
            end else if (pcnt_q == LIMIT) begin
              fail_addr <= addr_q;
              ok_q      <= 1'b0;
              hv_en     <= 1'b0;
              tmr_val   <= T_SETTLE;
              tmr_load  <= 1'b1;
              state_q   <= ST_HV_DOWN;
            end else begin
              bus_go   <= 1'b1;
              bus_wr   <= 1'b1;
              bus_addr <= '0;
              bus_data <= OP_ERASE;
              state_q  <= ST_SETUP;
            end
          end
        end
        ST_RESET: begin
          if (bus_fin) begin
            ok_q     <= 1'b1;
            hv_en    <= 1'b0;
            tmr_val  <= T_SETTLE;
            tmr_load <= 1'b1;
            state_q  <= ST_HV_DOWN;
          end
        end
        ST_HV_DOWN: begin
          if (tmr_exp) begin
            done    <= ok_q;
            err     <= !ok_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bulk_erase_seq_chk.sv
module bulk_erase_seq_chk #(
  parameter int ADDR_W     = 17,
  parameter int MAX_PULSES = 1000,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hv_en,
  input logic              prog_req,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic              done,
  input logic              err,
  input logic [CNT_W-1:0]  pulse_count
);

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_write)
                               && $stable(cmd_addr) && $stable(cmd_data));

  a_r9_cmd_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> hv_en);

  a_r9_req_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> hv_en);

  a_r1_no_cmd_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !cmd_valid);

  a_r5_done_hv_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hv_en);

  a_r6_err_hv_low: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !hv_en);

  a_r8_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= CNT_W'(MAX_PULSES));

endmodule

bind bulk_erase_seq bulk_erase_seq_chk #(
  .ADDR_W     (ADDR_W),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hv_en       (hv_en),
  .prog_req    (prog_req),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_write   (cmd_write),
  .cmd_addr    (cmd_addr),
  .cmd_data    (cmd_data),
  .done        (done),
  .err         (err),
  .pulse_count (pulse_count)
);

// File: tb/bulk_erase_seq_test.sv
`timescale 1ns/1ps
module bulk_erase_seq_test;

  localparam int AW     = 4;
  localparam int NB     = 1 << AW;
  localparam int PULSE  = 4;
  localparam int RECOV  = 2;
  localparam int SETTLE = 3;
  localparam int MAXP   = 1000;
  localparam int CW     = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          hv_en;
  logic          prog_req;
  logic          prog_ack = 1'b0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic          cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          rsp_valid = 1'b0;
  logic          rsp_ready;
  logic [7:0]    rsp_data = 8'h00;
  logic          done;
  logic          err;
  logic [AW-1:0] fail_addr;
  logic [CW-1:0] pulse_count;

  always #5 clk = ~clk;

  bulk_erase_seq #(
    .ADDR_W(AW), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV),
    .SETTLE_CYC(SETTLE), .MAX_PULSES(MAXP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hv_en(hv_en),
    .prog_req(prog_req), .prog_ack(prog_ack),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .err(err), .fail_addr(fail_addr), .pulse_count(pulse_count)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // flash model state
  int need [NB];
  int cyc = 0;
  int pulses_seen, reads_seen;
  int v_r1, v_r2, v_r3, v_r4;
  bit armed, prog_done, reset_seen, vaddr_valid;
  int pulse_cyc, vcmd_cyc;
  int vaddr, exp_next;
  bit rsp_pend, rsp_taken, ack_busy;
  int rsp_wait, ack_wait;
  logic [7:0] rsp_byte;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    pulses_seen = 0; reads_seen = 0;
    v_r1 = 0; v_r2 = 0; v_r3 = 0; v_r4 = 0;
    armed = 0; prog_done = 0; reset_seen = 0; vaddr_valid = 0;
    pulse_cyc = 0; vcmd_cyc = 0; vaddr = 0; exp_next = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    prog_ack = 1'b0;
    if (!rst_n) begin
      cmd_ready = 1'b0; rsp_valid = 1'b0;
      rsp_pend = 0; rsp_taken = 0; ack_busy = 0;
    end else begin
      if (rsp_taken) begin rsp_valid = 1'b0; rsp_taken = 0; end
      if (rsp_pend) begin
        if (rsp_wait == 0) begin
          rsp_valid = 1'b1; rsp_data = rsp_byte; rsp_pend = 0;
        end else rsp_wait--;
      end
      if (rsp_valid && rsp_ready) rsp_taken = 1;

      if (prog_req && !ack_busy) begin ack_busy = 1; ack_wait = $urandom % 5; end
      else if (ack_busy) begin
        if (ack_wait == 0) begin prog_ack = 1'b1; prog_done = 1; ack_busy = 0; end
        else ack_wait--;
      end

      cmd_ready = ($urandom % 4) != 0;
      if (cmd_valid && cmd_ready) begin
        if (!hv_en || !prog_done) v_r1++;
        if (cmd_write) begin
          if (cmd_data == 8'h20) begin
            if (armed) begin
              for (int i = 0; i < NB; i++) if (need[i] > 0) need[i]--;
              pulses_seen++; armed = 0; pulse_cyc = cyc;
            end else armed = 1;
          end else if (cmd_data == 8'hA0) begin
            if (armed) v_r2++;
            if (cyc - pulse_cyc < PULSE && vaddr_valid == 0 && int'(cmd_addr) == exp_next
                && reads_seen >= 0 && pulse_cyc >= vcmd_cyc) v_r2++;
            if (int'(cmd_addr) != exp_next) v_r4++;
            vaddr = int'(cmd_addr); vaddr_valid = 1; vcmd_cyc = cyc;
          end else if (cmd_data == 8'hFF) begin
            reset_seen = 1;
          end else v_r1++;
        end else begin
          if (!vaddr_valid || int'(cmd_addr) != vaddr) v_r3++;
          if (cyc - vcmd_cyc < RECOV) v_r3++;
          reads_seen++;
          rsp_pend = 1; rsp_wait = $urandom % 3;
          rsp_byte = (need[cmd_addr] == 0) ? 8'hFF : 8'($urandom % 255);
          exp_next = (need[cmd_addr] == 0) ? int'(cmd_addr) + 1 : int'(cmd_addr);
          vaddr_valid = 0;
        end
      end
    end
  end

  // expected outcome from the requirements
  function automatic void expect_run(input int nd [NB], output bit ok, output int p,
                                     output int fa, output int rd);
    int mx;
    mx = 0; ok = 1; fa = 0;
    for (int i = 0; i < NB; i++) begin
      if (nd[i] > MAXP) begin ok = 0; fa = i; break; end
      if (nd[i] > mx) mx = nd[i];
    end
    if (ok) begin
      p = (mx < 1) ? 1 : mx;
      rd = NB + p - 1;
    end else begin
      p = MAXP;
      rd = fa + MAXP;
    end
  endfunction

  task automatic run_case(input string name, input bit poke_start);
    int nd [NB];
    bit eok; int ep, efa, erd;
    int wait_req, guard;
    for (int i = 0; i < NB; i++) nd[i] = need[i];
    expect_run(nd, eok, ep, efa, erd);
    model_clear();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(hv_en == 1'b1, "R1 hv_en after start", hv_en, 1);
    wait_req = 1;
    while (!prog_req && wait_req < 100) begin @(negedge clk); wait_req++; end
    chk(wait_req >= SETTLE && prog_req, "R1 settle before prog_req", wait_req, SETTLE);
    guard = 0;
    while (!(done || err) && guard < 60000) begin
      @(negedge clk); guard++;
      if (poke_start && guard == 40) start = 1'b1;
      else start = 1'b0;
    end
    $display("case %s: pulses=%0d reads=%0d", name, pulses_seen, reads_seen);
    chk(done == eok, "R5 done", done, eok);
    chk(err == !eok, "R6 err", err, !eok);
    chk(int'(pulse_count) == ep, "R5 pulse_count", pulse_count, ep);
    chk(pulses_seen == ep, "R2 pulses applied", pulses_seen, ep);
    chk(reads_seen == erd, "R4 verify reads resume", reads_seen, erd);
    chk(reset_seen == eok, "R5 read-mode write", reset_seen, eok);
    if (!eok) chk(int'(fail_addr) == efa, "R6 fail_addr", fail_addr, efa);
    chk(hv_en == 1'b0, "R5 hv_en low at end", hv_en, 0);
    chk(v_r1 == 0, "R1 command order", v_r1, 0);
    chk(v_r2 == 0, "R2 pulse wait", v_r2, 0);
    chk(v_r3 == 0, "R3 verify addr and recovery", v_r3, 0);
    chk(v_r4 == 0, "R4 verify address sequence", v_r4, 0);
    @(negedge clk);
    chk(!done && !err, "R8 outcome is one cycle", done | err, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) need[i] = 0;
    repeat (3) @(negedge clk);
    chk(!hv_en && !prog_req, "R8 reset hv/req", hv_en | prog_req, 0);
    chk(!cmd_valid && !rsp_ready, "R8 reset bus", cmd_valid | rsp_ready, 0);
    chk(!done && !err, "R8 reset outcome", done | err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NB; i++) need[i] = 1;
    run_case("single pulse", 0);

    for (int i = 0; i < NB; i++) need[i] = 0;
    run_case("already blank", 0);

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NB; i++) need[i] = 1 + ($urandom % 6);
      run_case("random", 0);
    end

    for (int i = 0; i < NB; i++) need[i] = 1;
    need[NB-1] = 7;
    run_case("late slow byte, start poked (R8)", 1);

    for (int i = 0; i < NB; i++) need[i] = 2;
    need[3] = MAXP;
    run_case("exact limit", 0);

    for (int i = 0; i < NB; i++) need[i] = 1;
    need[5] = MAXP + 1;
    need[9] = MAXP + 500;
    run_case("limit exceeded", 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule